// File: doc/BRIEF.md
# Schoolbook Carry-less Polynomial Multiplier

This block forms the full, unreduced product of two binary polynomials. Each operand is `NQ` 64-bit words wide, 8 by default, which covers degree 511. The result has `2*NQ` words. Coefficients are bit positions, so addition is XOR and multiplication is carry-less. A host puts both operands on the input pins, pulses `start`, and waits for `done`. The operands are copied into the block when the start is accepted, so the host may change the input pins on the next cycle.

Inside, the work runs one word of operand A per clock cycle. For the current word of A, two banks of `NQ/2` carry-less 64x64 lanes multiply it against every word of B. One bank takes the even-numbered words of B and the other takes the odd-numbered words. Two products in the same bank start 128 bits apart, so their 128-bit results do not overlap. Each bank's output is therefore a plain concatenation and needs no XOR inside the bank. The even bank is folded into an even accumulator at a shift of 64 times the row number. The odd bank goes into an odd accumulator in the same way. One final cycle merges the two: the odd accumulator is shifted up by one word and XORed into the even accumulator. The same structure works for `NQ = 4`, with two lanes per bank.

Both ends of the block are plain control pins. There is no valid/ready handshake on either side. The block never applies back-pressure, and the result does not wait for the consumer. `product` holds its value until the next accepted start has run to completion, so a consumer may read it at any time after `done`.

Top module: `gf2_poly_mul_sb`

## Requirements
- R1: After a run, `product` equals the carry-less product of the captured A and B. Word i of each operand is bits [64i+63:64i], and the product of A word i with B word j lands at bit offset 64·(i+j).
- R2: `done` is high for exactly one cycle. It rises NQ+1 clock edges after the edge that accepted `start`, which is 9 edges for NQ=8 and 5 edges for NQ=4.
- R3: `busy` rises on the edge that accepts `start`. It stays high through all the row cycles and the merge cycle, and it is low in the cycle where `done` is high.
- R4: If `start` is raised while `busy` is high, it is ignored. The result and the timing of the current run do not change.
- R5: The operands are sampled only on the accepting edge. If `op_a` or `op_b` change after that edge, the result of the run is not affected.
- R6: The most significant bit of `product` is always zero.
- R7: While reset is applied, `busy` is 0, `done` is 0 and `product` is all zeros.
- R8: `product` does not change in any cycle except the one where `done` is high.
- R9: With NQ=4 (256-bit operands, two lanes per bank), R1 and R2 hold for the 512-bit product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when `busy` is low |
| op_a | input | NQ*64 | Multiplicand A; word i is bits [64i+63:64i] |
| op_b | input | NQ*64 | Multiplicand B, laid out the same way |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when `product` is updated |
| product | output | NQ*128 | Unreduced product A·B |

## Verification
The hardest case to reach from the ports is a run that is disturbed while it is in flight. The stimulus raises `start` again while `busy` is high, and it gives that second start different operands. In the cycle after acceptance it also scrambles `op_a` and `op_b`. Only an exact result and an unchanged `done` latency show that the block ignored the second start and used the captured operands. Edge operands are chosen to drive the top word of each bank and the shifted merge into the highest bits of the product:
- all ones in both operands;
- the top bit alone in both operands;
- a product of a single bit and a wide value.

An 8-word instance and a 4-word instance are both compared against a bit-serial reference.

// File: rtl/gf2pm_pkg.sv
package gf2pm_pkg;
  localparam int QW = 64;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROW   = 2'd1,
    ST_MERGE = 2'd2
  } seq_state_e;

  // Carry-less 64x64 multiply, 128-bit result.
  function automatic logic [2*QW-1:0] clmul_word(input logic [QW-1:0] x,
                                                 input logic [QW-1:0] y);
    logic [2*QW-1:0] acc;
    acc = '0;
    for (int k = 0; k < QW; k++) begin
      if (x[k]) acc = acc ^ ({{QW{1'b0}}, y} << k);
    end
    return acc;
  endfunction
endpackage

// File: rtl/gf2pm_bank.sv
module gf2pm_bank
  import gf2pm_pkg::*;
#(
  parameter int NQ  = 8,
  parameter int PAR = 0
) (
  input  logic [QW-1:0]    a_word,
  input  logic [NQ*QW-1:0] b_full,
  output logic [NQ*QW-1:0] bank_word
);
  localparam int LANES = NQ / 2;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int BJ = 2 * k + PAR;
    logic [2*QW-1:0] lane_prod;
    always_comb lane_prod = clmul_word(a_word, b_full[BJ*QW +: QW]);
    assign bank_word[k*2*QW +: 2*QW] = lane_prod;
  end
endmodule

// File: rtl/gf2pm_seq.sv
module gf2pm_seq
  import gf2pm_pkg::*;
#(
  parameter int NQ = 8,
  localparam int RW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          row_en,
  output logic          merge_en,
  output logic [RW-1:0] row_idx,
  output logic          busy
);
  seq_state_e state_q;
  logic [RW-1:0] row_q;

  assign accept   = start && (state_q == ST_IDLE);
  assign row_en   = (state_q == ST_ROW);
  assign merge_en = (state_q == ST_MERGE);
  assign row_idx  = row_q;
  assign busy     = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_ROW;
          row_q   <= '0;
        end
        ST_ROW: begin
          if (row_q == RW'(NQ - 1)) state_q <= ST_MERGE;
          else row_q <= row_q + 1'b1;
        end
        ST_MERGE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gf2pm_accum.sv
module gf2pm_accum
  import gf2pm_pkg::*;
#(
  parameter int NQ = 8,
  localparam int RW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int BW = NQ * QW,
  localparam int PW = 2 * NQ * QW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          row_en,
  input  logic          merge_en,
  input  logic [RW-1:0] row_idx,
  input  logic [BW-1:0] even_bank,
  input  logic [BW-1:0] odd_bank,
  output logic [PW-1:0] product,
  output logic          done
);
  logic [PW-1:0] even_acc, odd_acc;
  logic [PW-1:0] even_sh, odd_sh;

  always_comb begin
    even_sh = {{(PW-BW){1'b0}}, even_bank} << (int'(row_idx) * QW);
    odd_sh  = {{(PW-BW){1'b0}}, odd_bank}  << (int'(row_idx) * QW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      even_acc <= '0;
      odd_acc  <= '0;
    end else if (clear) begin
      even_acc <= '0;
      odd_acc  <= '0;
    end else if (row_en) begin
      even_acc <= even_acc ^ even_sh;
      odd_acc  <= odd_acc ^ odd_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= merge_en;
      if (merge_en) product <= even_acc ^ (odd_acc << QW);
    end
  end
endmodule

// File: rtl/gf2_poly_mul_sb.sv
module gf2_poly_mul_sb
  import gf2pm_pkg::*;
#(
  parameter int NQ = 8,
  localparam int RW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int BW = NQ * QW,
  localparam int PW = 2 * NQ * QW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BW-1:0] op_a,
  input  logic [BW-1:0] op_b,
  output logic          busy,
  output logic          done,
  output logic [PW-1:0] product
);
  logic          accept, row_en, merge_en;
  logic [RW-1:0] row_idx;
  logic [BW-1:0] a_q, b_q;
  logic [QW-1:0] a_row;
  logic [BW-1:0] even_bank, odd_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      a_q <= op_a;
      b_q <= op_b;
    end
  end

  assign a_row = a_q[int'(row_idx)*QW +: QW];

  gf2pm_seq #(.NQ(NQ)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .row_en(row_en), .merge_en(merge_en), .row_idx(row_idx), .busy(busy)
  );

  gf2pm_bank #(.NQ(NQ), .PAR(0)) u_even (
    .a_word(a_row), .b_full(b_q), .bank_word(even_bank)
  );

  gf2pm_bank #(.NQ(NQ), .PAR(1)) u_odd (
    .a_word(a_row), .b_full(b_q), .bank_word(odd_bank)
  );

  gf2pm_accum #(.NQ(NQ)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(accept), .row_en(row_en),
    .merge_en(merge_en), .row_idx(row_idx), .even_bank(even_bank),
    .odd_bank(odd_bank), .product(product), .done(done)
  );
endmodule

// File: rtl/gf2pm_checker.sv
module gf2pm_checker #(
  parameter int NQ = 8,
  localparam int PW = 2 * NQ * 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [PW-1:0] product
);
  logic [7:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (start && !busy) cyc <= 8'd1;
    else if (busy) cyc <= cyc + 8'd1;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc == 8'(NQ + 2))); // R2
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R3
  AST_RUN_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc <= 8'(NQ)) |=> (busy && cyc != 8'd1)); // R4
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !product[PW-1]); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product)); // R8
endmodule

bind gf2_poly_mul_sb gf2pm_checker #(.NQ(NQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .product(product)
);

// File: tb/test_gf2_poly_mul_sb.sv
module test_gf2_poly_mul_sb;
  localparam int CLK_NS = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, start_s = 1'b0;
  logic [511:0] op_a = '0, op_b = '0;
  logic [255:0] op_a_s = '0, op_b_s = '0;
  logic busy, done, busy_s, done_s;
  logic [1023:0] product;
  logic [511:0] product_s;

  int n_checks = 0;
  int n_errors = 0;
  logic [1023:0] exp_q[$];
  logic [511:0]  exp_s_q[$];

  always #(CLK_NS/2) clk = ~clk;

  gf2_poly_mul_sb #(.NQ(8)) i_gf2_poly_mul_sb (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  gf2_poly_mul_sb #(.NQ(4)) i_gf2_poly_mul_sb_small (
    .clk(clk), .rst_n(rst_n), .start(start_s), .op_a(op_a_s), .op_b(op_b_s),
    .busy(busy_s), .done(done_s), .product(product_s)
  );

  function automatic logic [1023:0] ref_mul(input logic [511:0] a, input logic [511:0] b);
    logic [1023:0] r;
    r = '0;
    for (int k = 0; k < 512; k++) if (a[k]) r = r ^ ({512'b0, b} << k);
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int w = 0; w < 16; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [1023:0] act, input logic [1023:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitors: pop expected results as each instance reports done.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected done", 1024'(done), 1024'(0));
      else begin
        logic [1023:0] e;
        e = exp_q.pop_front();
        check(product == e, "R1 product", product, e);
        check(!product[1023], "R6 top bit", 1024'(product[1023]), 1024'(0));
      end
    end
    if (rst_n && done_s) begin
      if (exp_s_q.size() == 0) check(1'b0, "R9 unexpected done", 1024'(done_s), 1024'(0));
      else begin
        logic [511:0] es;
        es = exp_s_q.pop_front();
        check(product_s == es, "R9 small product", 1024'(product_s), 1024'(es));
      end
    end
  end

  task automatic run_big(input logic [511:0] a, input logic [511:0] b, input logic disturb);
    logic [1023:0] e;
    e = ref_mul(a, b);
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    exp_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    op_a = rnd512(); op_b = rnd512(); // R5: scramble after capture
    check(busy == 1'b1, "R3 busy after accept", 1024'(busy), 1024'(1));
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (disturb && k == 2) begin start = 1'b1; op_a = ~a; op_b = rnd512(); end // R4
      if (k == 3) start = 1'b0;
    end
    check(busy == 1'b1 && done == 1'b0, "R2 no early done", {busy, done}, 1024'(2));
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R2 R3 done timing", {busy, done}, 1024'(1));
    repeat (4) @(negedge clk);
    check(product == e, "R8 result held", product, e);
  endtask

  task automatic run_small(input logic [255:0] a, input logic [255:0] b);
    logic [1023:0] e;
    e = ref_mul({256'b0, a}, {256'b0, b});
    @(negedge clk);
    op_a_s = a; op_b_s = b; start_s = 1'b1;
    exp_s_q.push_back(e[511:0]);
    @(posedge clk);
    @(negedge clk);
    start_s = 1'b0;
    op_a_s = ~a;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
    check(done_s == 1'b0, "R9 no early done", 1024'(done_s), 1024'(0));
    @(posedge clk);
    @(negedge clk);
    check(done_s == 1'b1, "R9 done after 5 edges", 1024'(done_s), 1024'(1));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R7 reset flags", {busy, done}, 1024'(0));
    check(product == '0, "R7 reset product", product, 1024'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_big('0, rnd512(), 1'b0);
    run_big({512{1'b1}}, {512{1'b1}}, 1'b0);
    run_big({1'b1, 511'b0}, {1'b1, 511'b0}, 1'b0);
    run_big(512'd1, rnd512(), 1'b0);
    run_big(rnd512(), 512'd1 << 448, 1'b0);
    for (int t = 0; t < 4; t++) run_big(rnd512(), rnd512(), 1'b0);
    run_big(rnd512(), rnd512(), 1'b1);
    run_big(rnd512(), rnd512(), 1'b1);

    run_small({256{1'b1}}, {256{1'b1}});
    run_small(rnd512() >> 256, rnd512() >> 256);
    run_small({1'b1, 255'b0}, 256'd3);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0 && exp_s_q.size() == 0, "R1 all results seen",
          1024'(exp_q.size() + exp_s_q.size()), 1024'(0));
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule